// File: doc/BRIEF.md
# Card Slot Status and Insertion Interrupt Block

This block is a small register window beside a removable-card slot. Software sees four word locations: a fixed identification word, a location that always reads zero, a status word, and a fixed decode word. The status word carries two slot signals. The write-protect bit is a live copy of the slot's write-protect level. The card-insert bit is sticky: any cycle in which the slot reports a card sets it, and only software can clear it.

The sticky card-insert bit drives the block's single interrupt line directly. An interrupt handler reads the status word and then writes it back with the card-insert bit set to acknowledge the event. Both slot levels come from outside the clock domain, so each passes through its own two-flop synchronizer first. The bus uses a single-cycle strobe. Read data and the error flag appear on the cycle after the access.

Top module: `cardslot_ctrl`

## Requirements
- R1: While reset is asserted and on release, `irq_o`, `bus_err_o` and `bus_rdata_o` are all zero and the card-insert bit is clear.
- R2: Status word (word offset 2) bit 0 equals the write-protect input as seen through a two-flop synchronizer, so a level change shows in reads that start two or more cycles later.
- R3: A high card-insert input, once it has passed the two-flop synchronizer, sets status bit 3 and raises `irq_o` on the next edge. A later low input does not clear the bit.
- R4: A write to offset 2 with data bit 3 set clears status bit 3 and drops `irq_o` on the next edge. Every other data bit of that write has no effect, and `irq_o` always equals status bit 3.
- R5: When a clearing write lands in a cycle where the synchronized card-insert level is high, the bit stays set and `irq_o` stays high.
- R6: Offset 0 reads 0x41034003, offset 1 reads 0x00000000 and offset 3 reads 0x00000011.
- R7: Writes to offsets 0, 1 and 3 change neither `irq_o` nor any value that is read back.
- R8: An access to any offset above 3 returns 0 as read data and raises `bus_err_o` for exactly the following cycle. An access to offsets 0 to 3 never raises `bus_err_o`.
- R9: `bus_rdata_o` is loaded only by a read access, on the edge that ends it. It holds its value through idle cycles and writes.
- R10: Status bits other than 0 and 3 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (4) | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| bus_err_o | output | 1 | One-cycle error pulse for an out-of-range access |
| wp_lvl_i | input | 1 | Slot write-protect level (asynchronous) |
| cd_lvl_i | input | 1 | Slot card-insert level (asynchronous) |
| irq_o | output | 1 | Card-insertion interrupt |

## Verification
The bench builds the block with ADDR_W = 4. This gives twelve offsets beyond the decoded window, so reads and writes at offsets 4, 7 and 15 can test the error pulse and the zero read data. SYNC_STAGES stays at 2. The three-edge path from a slot input to the interrupt is therefore short enough to place a clearing write in the exact cycle the synchronized insert level is high, which tests the set-wins rule against a short pulse and a held level.

// File: rtl/cardslot_pkg.sv
package cardslot_pkg;
  localparam int          DATA_W      = 32;
  localparam logic [31:0] ID_WORD     = 32'h4103_4003;
  localparam logic [31:0] DECODE_WORD = 32'h0000_0011;
  localparam int          WP_BIT      = 0;
  localparam int          CD_BIT      = 3;

  typedef enum logic [1:0] {
    OFS_ID   = 2'd0,
    OFS_PROG = 2'd1,
    OFS_STAT = 2'd2,
    OFS_DEC  = 2'd3
  } ofs_e;

  typedef struct packed {
    logic cd;
    logic wp;
  } slot_t;
endpackage

// File: rtl/cardslot_sync.sv
module cardslot_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stg_d;
      if (g == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_rest
        assign stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cardslot_latch.sv
module cardslot_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;  // set has priority over a clear in the same cycle
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cardslot_regs.sv
module cardslot_regs
  import cardslot_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  slot_t             slot_s_i,
  input  logic              flag_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(OFS_DEC);

  logic              in_range;
  ofs_e              ofs;
  logic [DATA_W-1:0] stat_word, rd_mux;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              err_q, err_d;

  always_comb begin
    in_range  = (acc_addr_i <= LAST_OFS);
    ofs       = ofs_e'(acc_addr_i[1:0]);
    stat_word = '0;
    stat_word[WP_BIT] = slot_s_i.wp;
    stat_word[CD_BIT] = flag_i;
    rd_mux = '0;
    if (in_range) begin
      unique case (ofs)
        OFS_ID:   rd_mux = ID_WORD;
        OFS_PROG: rd_mux = '0;
        OFS_STAT: rd_mux = stat_word;
        OFS_DEC:  rd_mux = DECODE_WORD;
        default:  rd_mux = '0;
      endcase
    end
    clr_o    = acc_en_i & acc_wr_i & in_range & (ofs == OFS_STAT) & acc_wdata_i[CD_BIT];
    rdata_en = acc_en_i & ~acc_wr_i;
    rdata_d  = rd_mux;
    err_d    = acc_en_i & ~in_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rdata_en) rdata_q <= rdata_d;
      err_q <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/cardslot_ctrl.sv
module cardslot_ctrl
  import cardslot_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_err_o,
  input  logic              wp_lvl_i,
  input  logic              cd_lvl_i,
  output logic              irq_o
);
  localparam int SLOT_W = $bits(slot_t);

  logic  [1:0] rst_sync_q;
  logic        rst_int_n;
  slot_t       slot_raw, slot_s;
  logic        flag, clr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign slot_raw.wp = wp_lvl_i;
  assign slot_raw.cd = cd_lvl_i;

  cardslot_sync #(.WIDTH(SLOT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (slot_raw),
    .q_o   (slot_s)
  );

  cardslot_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (slot_s.cd),
    .clr_i  (clr),
    .flag_o (flag)
  );

  cardslot_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .acc_en_i    (bus_en_i),
    .acc_wr_i    (bus_wr_i),
    .acc_addr_i  (bus_addr_i),
    .acc_wdata_i (bus_wdata_i),
    .slot_s_i    (slot_s),
    .flag_i      (flag),
    .clr_o       (clr),
    .rdata_o     (bus_rdata_o),
    .err_o       (bus_err_o)
  );

  assign irq_o = flag;
endmodule

// File: rtl/cardslot_ctrl_chk.sv
module cardslot_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              bus_err_o,
  input logic              irq_o,
  input logic              cd_s,
  input logic              wp_s
);
  logic clr_wr, stat_rd, oor, any_acc;
  assign clr_wr  = bus_en_i && bus_wr_i && (bus_addr_i == ADDR_W'(2)) && bus_wdata_i[3];
  assign stat_rd = bus_en_i && !bus_wr_i && (bus_addr_i == ADDR_W'(2));
  assign oor     = bus_en_i && (bus_addr_i > ADDR_W'(3));
  assign any_acc = bus_en_i;

  // R3
  insert_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cd_s |=> irq_o);

  // R3
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_wr) |=> irq_o);

  // R4
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !cd_s) |=> !irq_o);

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && cd_s) |=> irq_o);

  // R2
  wp_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata_o[0] == $past(wp_s)));

  // R10
  stat_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata_o[31:4] == 28'd0 && bus_rdata_o[2:1] == 2'd0));

  // R8
  oor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oor |=> (bus_err_o && bus_rdata_o == ($past(bus_wr_i) ? $past(bus_rdata_o) : 32'd0)));

  // R8
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_acc || !oor) |=> !bus_err_o);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en_i || bus_wr_i) |=> $stable(bus_rdata_o));
endmodule

bind cardslot_ctrl cardslot_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en_i    (bus_en_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .bus_err_o   (bus_err_o),
  .irq_o       (irq_o),
  .cd_s        (slot_s.cd),
  .wp_s        (slot_s.wp)
);

// File: tb/sim_cardslot_ctrl.sv
`timescale 1ns/1ps
module sim_cardslot_ctrl;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic          wp_lvl, cd_lvl;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  cardslot_ctrl #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_en_i    (bus_en),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .bus_err_o   (bus_err),
    .wp_lvl_i    (wp_lvl),
    .cd_lvl_i    (cd_lvl),
    .irq_o       (irq)
  );

  // ---------------- reference model ----------------
  int wp_hist[$];
  int cd_hist[$];
  int m_flag, m_err;
  int unsigned m_rdata;

  function automatic int unsigned read_value(int a, int wpv, int flg);
    if (a == 0) return 32'h4103_4003;
    if (a == 3) return 32'h11;
    if (a == 2) return (flg ? 8 : 0) + (wpv ? 1 : 0);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_hist = '{0, 0};
      cd_hist = '{0, 0};
      m_flag  = 0;
      m_err   = 0;
      m_rdata = 0;
    end else begin
      int wpv, cdv, nflag;
      wpv = wp_hist[0];
      cdv = cd_hist[0];
      nflag = m_flag;
      if (bus_en && bus_wr && bus_addr == 2 && bus_wdata[3]) nflag = 0;
      if (cdv != 0) nflag = 1;
      m_err = (bus_en && bus_addr > 3) ? 1 : 0;
      if (bus_en && !bus_wr) m_rdata = read_value(int'(bus_addr), wpv, m_flag);
      m_flag = nflag;
      void'(wp_hist.pop_front());
      void'(cd_hist.pop_front());
      wp_hist.push_back(int'(wp_lvl));
      cd_hist.push_back(int'(cd_lvl));
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bus_rdata !== m_rdata || bus_err !== m_err[0] || irq !== m_flag[0]) begin
        errors++;
        $display("FAIL %s model: actual rdata=%h err=%b irq=%b expected rdata=%h err=%0d irq=%0d",
                 phase, bus_rdata, bus_err, irq, m_rdata, m_err, m_flag);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, int a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = wr; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    bus_en = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    wp_lvl = 0; cd_lvl = 0;
    rst_n = 0;
    idle(3);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 err in reset", {31'd0, bus_err}, 32'd0);
    check("R1 rdata in reset", bus_rdata, 32'd0);
    rst_n = 1;
    idle(4);
    check("R1 irq after release", {31'd0, irq}, 32'd0);

    phase = "R6";
    access(0, 0, 0); check("R6 id word", bus_rdata, 32'h4103_4003);
    access(0, 1, 0); check("R6 offset 1", bus_rdata, 32'd0);
    access(0, 3, 0); check("R6 decode word", bus_rdata, 32'h11);

    phase = "R2";
    wp_lvl = 1; idle(3);
    access(0, 2, 0); check("R2 wp high", bus_rdata, 32'h1);
    wp_lvl = 0; idle(3);
    access(0, 2, 0); check("R2 wp low", bus_rdata, 32'h0);

    phase = "R3";
    @(negedge clk); cd_lvl = 1; @(negedge clk); cd_lvl = 0;
    idle(1);
    check("R3 irq not yet", {31'd0, irq}, 32'd0);
    idle(1);
    check("R3 irq set", {31'd0, irq}, 32'd1);
    idle(4);
    check("R3 irq sticky", {31'd0, irq}, 32'd1);
    phase = "R10";
    wp_lvl = 1; idle(3);
    access(0, 2, 0); check("R10 status with both bits", bus_rdata, 32'h9);

    phase = "R4";
    access(1, 2, 32'hFFFF_FFF7); check("R4 other bits ignored", {31'd0, irq}, 32'd1);
    access(1, 2, 32'h0000_0008); check("R4 clear drops irq", {31'd0, irq}, 32'd0);
    access(0, 2, 0); check("R4 status after clear", bus_rdata, 32'h1);

    phase = "R5";
    cd_lvl = 1; idle(4);
    access(1, 2, 32'h8); check("R5 set wins over clear", {31'd0, irq}, 32'd1);
    cd_lvl = 0; idle(3);
    access(1, 2, 32'h8); check("R5 clear once input low", {31'd0, irq}, 32'd0);

    phase = "R7";
    @(negedge clk); cd_lvl = 1; @(negedge clk); cd_lvl = 0; idle(4);
    access(1, 0, 32'hFFFF_FFFF);
    access(1, 1, 32'hFFFF_FFFF);
    access(1, 3, 32'hFFFF_FFFF);
    check("R7 irq untouched", {31'd0, irq}, 32'd1);
    access(0, 0, 0); check("R7 id unchanged", bus_rdata, 32'h4103_4003);
    access(0, 3, 0); check("R7 decode unchanged", bus_rdata, 32'h11);
    access(0, 2, 0); check("R7 status unchanged", bus_rdata, 32'h9);
    access(1, 2, 32'h8);

    phase = "R8";
    access(0, 4, 0);
    check("R8 err pulse", {31'd0, bus_err}, 32'd1);
    check("R8 zero data", bus_rdata, 32'd0);
    idle(1);
    check("R8 err one cycle", {31'd0, bus_err}, 32'd0);
    access(0, 0, 0); check("R8 no err in range", {31'd0, bus_err}, 32'd0);
    access(1, 15, 32'hFFFF_FFFF);
    check("R8 err on write", {31'd0, bus_err}, 32'd1);
    access(0, 7, 0); check("R8 zero data offset 7", bus_rdata, 32'd0);

    phase = "R9";
    access(0, 3, 0);
    idle(3);
    check("R9 rdata holds idle", bus_rdata, 32'h11);
    access(1, 1, 32'h1234_5678);
    check("R9 rdata holds on write", bus_rdata, 32'h11);

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule